// File: doc/BRIEF.md
# Address-Tagged Serial Remote Encoder

This block turns an 8-bit receiver address and a 4-bit data nibble into a pulse-width coded serial stream on one output line. The stream is meant for an on/off keyed radio link that feeds a receiver which filters on the address. The receiver side, the modulator and the antenna are outside this block. The 8-bit address field can select any one of 256 receivers.

Sending is controlled by an active-low request input. Holding the request low makes the block send complete words back to back. Each word starts with a long low pilot, followed by a short high sync pulse and then twelve coded bits. The address and nibble inputs are captured at the first cycle of each word. A word that has started is always finished, even when the request is released partway through. A divider parameter sets the length of one sub-slot in clock cycles, and therefore the bit rate.

Top module: `remote_word_encoder`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `busy` and `line_out` are both 0.
- R2: While no word is being sent, `line_out` is 0 and `busy` is 0, whatever `tag_addr` and `tag_data` do.
- R3: If `send_n` is sampled low at a clock edge while idle, `busy` is 1 from that edge on, and the first pilot sub-slot begins at that same edge.
- R4: Every word opens with a pilot of 12 bit-times (36 sub-slots) in which `line_out` is 0.
- R5: The pilot is followed by a sync pulse: one sub-slot with `line_out` at 1.
- R6: Each bit is sent as three sub-slots of SUB_CYC clock cycles each. A 0 is sent as low, high, high. A 1 is sent as low, low, high.
- R7: Bits are sent in this order: the address LSB first (`tag_addr[0]` to `tag_addr[7]`), then the nibble LSB first (`tag_data[0]` to `tag_data[3]`).
- R8: If `send_n` is low at the edge that ends a word's last sub-slot, the pilot of the next word starts at that edge, with no idle cycle in between.
- R9: `tag_addr` and `tag_data` are sampled only at the edge where a word starts. Changes made during a word do not affect that word.
- R10: If `send_n` is high at the edge that ends a word, the block returns to idle at that edge. Releasing `send_n` in the middle of a word never shortens the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tag_addr | input | 8 | Receiver address to be sent |
| tag_data | input | 4 | Data nibble to be sent |
| send_n | input | 1 | Send request, active low |
| line_out | output | 1 | Serial coded output |
| busy | output | 1 | High while a word is in progress |

## Verification
The hardest situation to reach is the boundary between two words while the request is held. At that single edge, the block must reload new inputs and restart the pilot with no idle cycle, while values that changed in the middle of the previous word must be ignored. The stimulus schedules every input change in whole word lengths, measured from the edge that started the first word. It changes the inputs to decoy values halfway through each word, and loads the next intended values one negative edge before the boundary. The scoreboard holds one expected level per clock cycle, so a gap, a stale capture or a shortened last word shows up as a level mismatch or a `busy` mismatch.

// File: rtl/remote_enc_pkg.sv
package remote_enc_pkg;

    // Sub-slots per coded bit.
    localparam int SLOTS_PER_BIT = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PILOT = 2'd1,
        ST_SYNC  = 2'd2,
        ST_BITS  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        PH_LEAD = 2'd0,
        PH_MID  = 2'd1,
        PH_TAIL = 2'd2
    } bit_phase_e;

    typedef struct packed {
        tx_state_e  state;
        bit_phase_e phase;
        logic       cur_bit;
    } line_ctrl_t;

    // Line level for a given position in the frame.
    function automatic logic slot_level(line_ctrl_t c);
        logic lvl;
        case (c.state)
            ST_SYNC: lvl = 1'b1;
            ST_BITS: begin
                case (c.phase)
                    PH_LEAD: lvl = 1'b0;
                    PH_MID:  lvl = ~c.cur_bit;
                    default: lvl = 1'b1;
                endcase
            end
            default: lvl = 1'b0;
        endcase
        return lvl;
    endfunction

    function automatic bit_phase_e next_phase(bit_phase_e p);
        bit_phase_e n;
        case (p)
            PH_LEAD: n = PH_MID;
            PH_MID:  n = PH_TAIL;
            default: n = PH_LEAD;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/remote_enc_tick.sv
module remote_enc_tick #(
    parameter int SUB_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (SUB_CYC > 1) ? $clog2(SUB_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SUB_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/remote_enc_seq.sv
module remote_enc_seq
    import remote_enc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 4,
    parameter int PILOT_BITS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              send_n,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [DATA_W-1:0] tag_data,
    output logic              running,
    output line_ctrl_t        ctrl
);
    localparam int WORD_W      = ADDR_W + DATA_W;
    localparam int PILOT_SLOTS = PILOT_BITS * SLOTS_PER_BIT;
    localparam int IW          = $clog2(WORD_W);
    localparam int PW          = $clog2(PILOT_SLOTS);
    localparam logic [IW-1:0] LAST_BIT   = IW'(WORD_W - 1);
    localparam logic [PW-1:0] LAST_PILOT = PW'(PILOT_SLOTS - 1);

    tx_state_e         state_q;
    bit_phase_e        phase_q;
    logic [IW-1:0]     idx_q;
    logic [PW-1:0]     slot_q;
    logic [WORD_W-1:0] word_q;

    logic word_done;
    assign word_done = tick && (state_q == ST_BITS) &&
                       (phase_q == PH_TAIL) && (idx_q == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= PH_LEAD;
            idx_q   <= '0;
            slot_q  <= '0;
            word_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (!send_n) begin
                        state_q <= ST_PILOT;
                        slot_q  <= '0;
                        word_q  <= {tag_data, tag_addr};
                    end
                end
                ST_PILOT: begin
                    if (tick) begin
                        if (slot_q == LAST_PILOT) begin
                            state_q <= ST_SYNC;
                            slot_q  <= '0;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                ST_SYNC: begin
                    if (tick) begin
                        state_q <= ST_BITS;
                        phase_q <= PH_LEAD;
                        idx_q   <= '0;
                    end
                end
                default: begin
                    if (word_done) begin
                        phase_q <= PH_LEAD;
                        idx_q   <= '0;
                        if (!send_n) begin
                            state_q <= ST_PILOT;
                            slot_q  <= '0;
                            word_q  <= {tag_data, tag_addr};
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else if (tick) begin
                        phase_q <= next_phase(phase_q);
                        if (phase_q == PH_TAIL) begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign running       = (state_q != ST_IDLE);
    assign ctrl.state    = state_q;
    assign ctrl.phase    = phase_q;
    assign ctrl.cur_bit  = word_q[idx_q];
endmodule

// File: rtl/remote_enc_line.sv
module remote_enc_line
    import remote_enc_pkg::*;
(
    input  line_ctrl_t ctrl,
    output logic       level
);
    assign level = slot_level(ctrl);
endmodule

// File: rtl/remote_word_encoder.sv
module remote_word_encoder
    import remote_enc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 4,
    parameter int PILOT_BITS = 12,
    parameter int SUB_CYC    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [DATA_W-1:0] tag_data,
    input  logic              send_n,
    output logic              line_out,
    output logic              busy
);
    logic       tick;
    logic       running;
    line_ctrl_t ctrl;

    remote_enc_tick #(.SUB_CYC(SUB_CYC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (running),
        .tick (tick)
    );

    remote_enc_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PILOT_BITS (PILOT_BITS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .send_n   (send_n),
        .tag_addr (tag_addr),
        .tag_data (tag_data),
        .running  (running),
        .ctrl     (ctrl)
    );

    remote_enc_line u_line (
        .ctrl  (ctrl),
        .level (line_out)
    );

    assign busy = running;
endmodule

// File: rtl/remote_word_encoder_chk.sv
module remote_word_encoder_chk #(
    parameter int SUB_CYC = 4
) (
    input logic clk,
    input logic rst,
    input logic send_n,
    input logic line_out,
    input logic busy
);
    logic [15:0] high_run_q;

    always_ff @(posedge clk) begin
        if (rst || !line_out) begin
            high_run_q <= '0;
        end else if (high_run_q != 16'hFFFF) begin
            high_run_q <= high_run_q + 1'b1;
        end
    end

    // R1: the block leaves reset idle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!busy && !line_out));

    // R2: the line is quiet whenever no word is in flight
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !line_out);

    // R3: a low request while idle starts a word at the next edge
    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && !send_n) |=> busy);

    // R4: a word always opens with the line low
    p_pilot_low_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !line_out);

    // R6: no high stretch is longer than two sub-slots
    p_high_run_r6: assert property (@(posedge clk) disable iff (rst)
        line_out |-> (high_run_q < 16'(2 * SUB_CYC)));

    // R10: the block goes idle only when the request was released
    p_stop_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(send_n));
endmodule

bind remote_word_encoder remote_word_encoder_chk #(.SUB_CYC(SUB_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .send_n   (send_n),
    .line_out (line_out),
    .busy     (busy)
);

// File: tb/remote_word_encoder_tb.sv
module remote_word_encoder_tb;
    localparam int SUB      = 3;
    localparam int WORD_CYC = (12 * 3 + 1 + 12 * 3) * SUB;
    localparam int LIMIT    = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tag_addr = 8'h00;
    logic [3:0] tag_data = 4'h0;
    logic       send_n = 1'b1;
    logic       line_out;
    logic       busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic  lvl;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    remote_word_encoder #(.SUB_CYC(SUB)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .tag_addr (tag_addr),
        .tag_data (tag_data),
        .send_n   (send_n),
        .line_out (line_out),
        .busy     (busy)
    );

    task automatic push_lvl(input logic v, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.lvl = v;
            e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    // Expected waveform of one word, one entry per clock cycle
    task automatic push_word(input logic [7:0] a, input logic [3:0] d, input string start_tag, input string bit_tag);
        logic [11:0] w;
        w = {d, a};
        push_lvl(1'b0, 1, start_tag);
        push_lvl(1'b0, 36 * SUB - 1, "R4");
        push_lvl(1'b1, SUB, "R5");
        for (int i = 0; i < 12; i++) begin
            push_lvl(1'b0, SUB, "R6");
            push_lvl(~w[i], SUB, bit_tag);
            push_lvl(1'b1, SUB, "R6");
        end
    endtask

    // Called just after a negedge; returns just after the negedge that precedes the word boundary
    task automatic send_word(input logic [7:0] a, input logic [3:0] d, input string start_tag,
                             input string bit_tag, input bit keep, input logic [7:0] ja, input logic [3:0] jd);
        tag_addr = a;
        tag_data = d;
        send_n   = 1'b0;
        push_word(a, d, start_tag, bit_tag);
        repeat (WORD_CYC / 2) @(negedge clk);
        #1;
        tag_addr = ja;
        tag_data = jd;
        if (!keep) send_n = 1'b1;
        repeat (WORD_CYC - WORD_CYC / 2) @(negedge clk);
        #1;
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: one comparison per cycle, away from the active edge
    always @(negedge clk) begin
        if (mon_on && !done) begin
            n_cmp++;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                if (busy !== 1'b1 || line_out !== e.lvl) begin
                    n_bad++;
                    $display("FAIL %s: busy=%b line=%b expected busy=1 line=%b at %0t",
                             e.tag, busy, line_out, e.lvl, $time);
                end
            end else begin
                if (busy !== 1'b0 || line_out !== 1'b0) begin
                    n_bad++;
                    $display("FAIL R2/R10: busy=%b line=%b expected busy=0 line=0 at %0t",
                             busy, line_out, $time);
                end
            end
        end
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion within %0d cycles", LIMIT);
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (busy !== 1'b0 || line_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: busy=%b line=%b expected 0 0", busy, line_out);
        end
        #1;
        rst = 1'b0;
        mon_on = 1'b1;

        // R2: input activity with the request high has no effect
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #1;
            tag_addr = 8'(i * 37 + 5);
            tag_data = 4'(i);
        end
        @(negedge clk);
        #1;

        // R3, R7, R10: single word, request released halfway through
        send_word(8'hA5, 4'h3, "R3", "R7", 1'b0, 8'h5A, 4'hC);
        repeat (5) @(negedge clk);
        #1;

        // R8, R9: held request, decoys mid-word, new values loaded just before the boundary
        send_word(8'h3C, 4'hE, "R3", "R9", 1'b1, 8'hFF, 4'h0);
        send_word(8'h81, 4'h6, "R8", "R9", 1'b0, 8'h00, 4'hF);
        repeat (4) @(negedge clk);
        #1;

        // R6, R8: all-ones word followed by an all-zeros word
        send_word(8'hFF, 4'hF, "R3", "R6", 1'b1, 8'h12, 4'h9);
        send_word(8'h00, 4'h0, "R8", "R6", 1'b0, 8'hEE, 4'h7);
        repeat (8) @(negedge clk);

        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R10: %0d expected cycles left unsent, expected 0", exp_q.size());
        end
        done = 1'b1;
        report();
        $finish;
    end
endmodule